// File: doc/BRIEF.md
# Processor Run-State Controller

This block holds the run state of a small stack-machine processor and decides when the datapath may execute. After reset it waits while a program is loaded. When it sees the load-complete strobe, it lets the datapath run. It watches each instruction's outcome: completion, a valid halt, or one of several classified failures. If it sees a halt or a failure, it freezes execution for good.

A failure is any of four exception inputs: an undecodable opcode, a program counter moved outside the program array, a stack overflow or underflow, or an access to an operand or destination that is not available. A fifth cause covers a silent stall, which is an execute request that ends with no completion, halt or failure. The cause of the first failure is kept in a sticky code so software or debug logic can read it after the machine stops. Only reset leaves the halted and failed states.

Top module: `run_state_ctrl`

## Requirements
- R1: Reset forces state_o to LOADING (state codes: 0 LOADING, 1 RUNNING, 2 HALTED, 3 FAILED), exec_en_o low and cause_o zero. The block stays in LOADING, with every input other than load_done_i ignored, until load_done_i is seen high.
- R2: In LOADING, load_done_i high at a clock edge moves the state to RUNNING at that edge.
- R3: In RUNNING, a cycle with instr_done_i high, or with no exec_req_i, and with no halt or exception keeps the state at RUNNING. exec_en_o is high exactly while the state is RUNNING.
- R4: In RUNNING, halt_i high with no exception input moves the state to HALTED and leaves cause_o at zero.
- R5: In RUNNING, any exception input high moves the state to FAILED at the next edge, even when halt_i or instr_done_i is also high.
- R6: HALTED and FAILED are terminal. No input other than reset changes state_o or cause_o, and exec_en_o stays low.
- R7: When the block enters FAILED because of exceptions, cause_o takes the code of the highest-priority exception asserted: 1 opcode, 2 PC range, 3 stack, 4 operand availability, with 1 the highest priority.
- R8: In RUNNING, exec_req_i high with instr_done_i, halt_i and all exception inputs low moves the state to FAILED with cause_o equal to 5 (implicit deadlock).
- R9: cause_o is zero whenever the state is not FAILED. Once set, it holds its value until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_done_i | input | 1 | Program load complete strobe |
| exec_req_i | input | 1 | Datapath is executing an instruction this cycle |
| instr_done_i | input | 1 | Instruction completed successfully |
| halt_i | input | 1 | Valid halt instruction executed |
| exc_opcode_i | input | 1 | Undecodable instruction |
| exc_pc_range_i | input | 1 | PC increment or overwrite outside program array |
| exc_stack_i | input | 1 | Stack overflow or underflow |
| exc_operand_i | input | 1 | Unavailable operand read or destination write |
| state_o | output | 2 | Current run state |
| exec_en_o | output | 1 | Execute enable to the datapath |
| cause_o | output | 3 | Sticky failure cause code |

## Verification
On every cycle, the assertions check the following: the LOADING exit condition, that the terminal states hold, that exec_en_o is low outside RUNNING, that failure wins over halt, the deadlock code, the opcode-first priority, and that cause_o is zero outside FAILED and stable inside it. Only the bench scenarios can show the full priority order across mixed exception sets, that stimulus in LOADING has no effect, and how the block behaves across several reset and run sequences. The bench's reference model checks those outcomes at the ports on every cycle.

// File: rtl/run_state_pkg.sv
package run_state_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_FAIL = 2'd3
  } run_state_e;

  localparam int unsigned NUM_EXC = 4;
  localparam int unsigned CAUSE_W = 3;
endpackage

// File: rtl/rsc_cause_arb.sv
module rsc_cause_arb #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] exc_i,
  output logic         any_o,
  output logic [W-1:0] code_o
);
  // bit 0 is the highest priority; code = index + 1
  always_comb begin
    any_o  = |exc_i;
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (exc_i[i]) code_o = W'(i + 1);
    end
  end
endmodule

// File: rtl/rsc_state_fsm.sv
module rsc_state_fsm
  import run_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_done_i,
  input  logic       halt_i,
  input  logic       fail_i,
  output run_state_e state_o,
  output logic       run_o
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOAD: if (load_done_i) state_d = ST_RUN;
      ST_RUN: begin
        if (fail_i)      state_d = ST_FAIL;
        else if (halt_i) state_d = ST_HALT;
      end
      default: state_d = state_q;  // terminal
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOAD;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign run_o   = (state_q == ST_RUN);
endmodule

// File: rtl/rsc_cause_reg.sv
module rsc_cause_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cause_o <= '0;
    else if (capture_i) cause_o <= code_i;
  end
endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
  import run_state_pkg::*;
#(
  parameter int unsigned N_EXC = NUM_EXC,
  parameter int unsigned C_W   = CAUSE_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_done_i,
  input  logic           exec_req_i,
  input  logic           instr_done_i,
  input  logic           halt_i,
  input  logic           exc_opcode_i,
  input  logic           exc_pc_range_i,
  input  logic           exc_stack_i,
  input  logic           exc_operand_i,
  output logic [1:0]     state_o,
  output logic           exec_en_o,
  output logic [C_W-1:0] cause_o
);
  localparam logic [C_W-1:0] DEADLOCK_CODE = C_W'(N_EXC + 1);

  logic [N_EXC-1:0] exc_vec;
  logic             exc_any;
  logic [C_W-1:0]   exc_code;
  logic             stall;
  logic             fail;
  logic             run;
  run_state_e       state;

  // priority order: opcode, pc range, stack, operand
  assign exc_vec = N_EXC'({exc_operand_i, exc_stack_i, exc_pc_range_i, exc_opcode_i});

  rsc_cause_arb #(.N(N_EXC), .W(C_W)) u_arb (
    .exc_i  (exc_vec),
    .any_o  (exc_any),
    .code_o (exc_code)
  );

  assign stall = exec_req_i & ~instr_done_i & ~halt_i & ~exc_any;
  assign fail  = exc_any | stall;

  rsc_state_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_done_i (load_done_i),
    .halt_i      (halt_i),
    .fail_i      (fail),
    .state_o     (state),
    .run_o       (run)
  );

  rsc_cause_reg #(.W(C_W)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (run & fail),
    .code_i    (exc_any ? exc_code : DEADLOCK_CODE),
    .cause_o   (cause_o)
  );

  assign state_o   = state;
  assign exec_en_o = run;
endmodule

// File: rtl/run_state_ctrl_chk.sv
module run_state_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_done_i,
  input logic       exec_req_i,
  input logic       instr_done_i,
  input logic       halt_i,
  input logic       exc_opcode_i,
  input logic       exc_pc_range_i,
  input logic       exc_stack_i,
  input logic       exc_operand_i,
  input logic [1:0] state_o,
  input logic       exec_en_o,
  input logic [2:0] cause_o
);
  logic any_exc;
  assign any_exc = exc_opcode_i | exc_pc_range_i | exc_stack_i | exc_operand_i;

  a_r1_hold_loading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !load_done_i) |=> state_o == 2'd0);
  a_r2_load_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && load_done_i) |=> state_o == 2'd1);
  a_r3_enable_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en_o == (state_o == 2'd1));
  a_r4_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && halt_i && !any_exc) |=> (state_o == 2'd2 && cause_o == 3'd0));
  a_r5_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && any_exc) |=> state_o == 2'd3);
  a_r6_halt_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |=> state_o == 2'd2);
  a_r6_fail_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 |=> state_o == 2'd3);
  a_r7_opcode_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && exc_opcode_i) |=> cause_o == 3'd1);
  a_r8_deadlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && exec_req_i && !instr_done_i && !halt_i && !any_exc)
    |=> (state_o == 2'd3 && cause_o == 3'd5));
  a_r9_zero_outside_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3 |-> cause_o == 3'd0);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 |=> $stable(cause_o));
endmodule

bind run_state_ctrl run_state_ctrl_chk u_chk (.*);

// File: tb/run_state_ctrl_test.sv
module run_state_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_done_i = 1'b0, exec_req_i = 1'b0, instr_done_i = 1'b0, halt_i = 1'b0;
  logic       exc_opcode_i = 1'b0, exc_pc_range_i = 1'b0, exc_stack_i = 1'b0, exc_operand_i = 1'b0;
  logic [1:0] state_o;
  logic       exec_en_o;
  logic [2:0] cause_o;

  int checks = 0;
  int errors = 0;
  int exp_state = 0;
  int exp_cause = 0;

  always #5 clk_i = ~clk_i;

  run_state_ctrl uut (.*);

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic compare(input string tag);
    checks++;
    if (int'(state_o) != exp_state || exec_en_o != (exp_state == 1) || int'(cause_o) != exp_cause) begin
      errors++;
      $display("FAIL %s: state=%0d en=%0b cause=%0d expected state=%0d en=%0b cause=%0d",
               tag, state_o, exec_en_o, cause_o, exp_state, exp_state == 1, exp_cause);
    end
  endtask

  // reference model: one clock edge
  task automatic model_edge();
    bit any;
    any = exc_opcode_i | exc_pc_range_i | exc_stack_i | exc_operand_i;
    if (exp_state == 0) begin
      if (load_done_i) exp_state = 1;
    end else if (exp_state == 1) begin
      if (any) begin
        exp_state = 3;
        if (exc_opcode_i)        exp_cause = 1;
        else if (exc_pc_range_i) exp_cause = 2;
        else if (exc_stack_i)    exp_cause = 3;
        else                     exp_cause = 4;
      end else if (halt_i) begin
        exp_state = 2;
      end else if (exec_req_i && !instr_done_i) begin
        exp_state = 3;
        exp_cause = 5;
      end
    end
  endtask

  // ex = {operand, stack, pc_range, opcode}
  task automatic step(input string tag, input logic ld, input logic req, input logic done,
                      input logic hlt, input logic [3:0] ex);
    load_done_i = ld; exec_req_i = req; instr_done_i = done; halt_i = hlt;
    {exc_operand_i, exc_stack_i, exc_pc_range_i, exc_opcode_i} = ex;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    load_done_i = 0; exec_req_i = 0; instr_done_i = 0; halt_i = 0;
    {exc_operand_i, exc_stack_i, exc_pc_range_i, exc_opcode_i} = '0;
    exp_state = 0; exp_cause = 0;
    @(negedge clk_i);
    compare("R1 reset");
    rst_ni = 1'b1;
  endtask

  task automatic fail_case(input string tag, input logic hlt, input logic [3:0] ex);
    do_reset();
    step("R2 load", 1, 0, 0, 0, 4'b0);
    step(tag, 0, 1, 1, hlt, ex);
    step("R6 frozen", 1, 1, 0, 1, 4'b1111);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    // R1: stimulus in LOADING has no effect
    step("R1 idle", 0, 0, 0, 0, 4'b0);
    step("R1 exc ignored", 0, 1, 0, 1, 4'b1111);
    step("R1 req ignored", 0, 1, 0, 0, 4'b0);
    step("R2 load", 1, 0, 0, 0, 4'b0);
    step("R3 exec done", 0, 1, 1, 0, 4'b0);
    step("R3 idle", 0, 0, 0, 0, 4'b0);
    step("R3 exec done", 0, 1, 1, 0, 4'b0);
    step("R4 halt", 0, 1, 1, 1, 4'b0);
    step("R6 halted", 1, 1, 0, 0, 4'b0);
    step("R6 halted exc", 0, 1, 1, 1, 4'b1111);
    step("R6 halted stall", 0, 1, 0, 0, 4'b0);

    // R5, R7 priority
    fail_case("R7 all exc code1", 0, 4'b1111);
    fail_case("R7 pc code2", 0, 4'b1110);
    fail_case("R7 stack code3", 0, 4'b1100);
    fail_case("R7 operand code4", 0, 4'b1000);
    fail_case("R5 exc beats halt", 1, 4'b0100);

    // R8 deadlock
    do_reset();
    step("R2 load", 1, 0, 0, 0, 4'b0);
    step("R3 exec done", 0, 1, 1, 0, 4'b0);
    step("R8 stall", 0, 1, 0, 0, 4'b0);
    step("R9 sticky", 0, 0, 0, 0, 4'b0001);
    step("R9 sticky", 0, 1, 1, 1, 4'b0100);

    // R8 halt counts as an indication
    do_reset();
    step("R2 load", 1, 0, 0, 0, 4'b0);
    step("R8 halt no stall", 0, 1, 0, 1, 4'b0);

    // R9 cleared by reset
    do_reset();
    step("R9 cleared", 0, 0, 0, 0, 4'b0);

    summary();
    $finish;
  end
endmodule